// File: doc/BRIEF.md
# Descriptor Action Condition Evaluator

This block decides, for the descriptor a channel is currently executing, whether its three conditional actions take effect: raising an interrupt request, holding the channel in a wait, and branching to the dependent descriptor address. Each action has its own 2-bit mode taken from the command word and its own select register. A select register carries a mask and a compare value. The block compares these against the low device-status bits of the channel.

A sequencer presents the command fields, the device status, the three select registers, the current descriptor pointer and the dependent address. It then pulses the evaluate strobe for one cycle. On that clock edge the block registers one decision. The interrupt request and a decision-valid flag are one-cycle pulses. The wait flag, the branch flag and the chosen next descriptor pointer hold until the next strobe.

Top module: `desc_cond_eval`

## Requirements
- R1: After reset, every output is 0, including the whole next-pointer value.
- R2: In a select register, bits 19:16 are the mask and bits 3:0 are the compare value. No other bit changes any decision.
- R3: An action's condition is true when (device status AND mask) equals (compare value AND mask). A mask of zero therefore always gives a true condition.
- R4: Every mode field uses the same encoding. 2'b00 never fires. 2'b01 fires when the condition is true. 2'b10 fires when the condition is false. 2'b11 always fires.
- R5: In the never and always modes, the result depends on neither the select register nor the device status.
- R6: The interrupt, branch and wait actions each test only their own select register.
- R7: When the branch fires, the next pointer is the dependent address and the branch flag is 1. Otherwise, the next pointer is the current pointer plus 16 (wrapping at the address width) and the branch flag is 0.
- R8: The interrupt request is high for exactly the one cycle after a strobe whose interrupt action fires. The decision-valid output is high for exactly the one cycle after every strobe.
- R9: On an edge without the strobe, the wait flag, the branch flag and the next pointer keep their values, whatever the inputs do. The interrupt request and decision-valid outputs are 0 after such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval_i | input | 1 | Evaluate strobe; one decision is registered per high cycle |
| irq_mode_i | input | 2 | Interrupt action mode |
| br_mode_i | input | 2 | Branch action mode |
| wait_mode_i | input | 2 | Wait action mode |
| dev_stat_i | input | STAT_W (4) | Low device-status bits of the channel |
| irq_sel_i | input | SEL_W (32) | Interrupt select register |
| br_sel_i | input | SEL_W (32) | Branch select register |
| wait_sel_i | input | SEL_W (32) | Wait select register |
| cur_ptr_i | input | ADDR_W (32) | Address of the current descriptor |
| dep_addr_i | input | ADDR_W (32) | Dependent (branch target) address of the descriptor |
| irq_req_o | output | 1 | One-cycle interrupt request |
| wait_o | output | 1 | Wait action fired |
| branch_o | output | 1 | Branch fired; selects the dependent address and serves as branch-taken status |
| next_ptr_o | output | ADDR_W (32) | Next descriptor address |
| dec_valid_o | output | 1 | One-cycle pulse marking a new decision |

## Verification
Every result passes through exactly one register. A strobe sampled at rising edge N therefore shows on every output from edge N onward. The pulses drop again after edge N+1 unless another strobe arrives.

The bench drives inputs and the strobe just after a falling edge. It compares all outputs at the next falling edge, half a period after the registering edge. It then takes the strobe low and checks, one edge later, that both pulses have fallen and that the held outputs still match the previous decision.

Expected values come from bench functions for the masked compare and the mode table. These functions are applied to random and directed stimulus.

// File: rtl/dce_pkg.sv
package dce_pkg;
   typedef enum logic [1:0] {
      MODE_NEVER  = 2'b00,
      MODE_IF_T   = 2'b01,
      MODE_IF_F   = 2'b10,
      MODE_ALWAYS = 2'b11
   } act_mode_e;

   localparam int unsigned N_ACT   = 3;
   localparam int unsigned ACT_IRQ = 0;
   localparam int unsigned ACT_BR  = 1;
   localparam int unsigned ACT_WT  = 2;
endpackage

// File: rtl/dce_match.sv
module dce_match #(
   parameter int unsigned STAT_W   = 4,
   parameter int unsigned SEL_W    = 32,
   parameter int unsigned MASK_LSB = 16,
   parameter int unsigned VAL_LSB  = 0
) (
   input  logic [STAT_W-1:0] stat_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              match_o
);
   logic [STAT_W-1:0] mask_w, val_w;

   assign mask_w  = sel_i[MASK_LSB +: STAT_W];
   assign val_w   = sel_i[VAL_LSB +: STAT_W];
   assign match_o = ((stat_i & mask_w) == (val_w & mask_w));

   always_comb begin
      if (mask_w == '0) begin
         assert_zero_mask_R3: assert (match_o);
      end
   end
endmodule

// File: rtl/dce_decide.sv
module dce_decide
   import dce_pkg::*;
(
   input  act_mode_e mode_i,
   input  logic      match_i,
   output logic      fire_o
);
   always_comb begin
      unique case (mode_i)
         MODE_NEVER:  fire_o = 1'b0;
         MODE_IF_T:   fire_o = match_i;
         MODE_IF_F:   fire_o = !match_i;
         MODE_ALWAYS: fire_o = 1'b1;
         default:     fire_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/dce_nextptr.sv
module dce_nextptr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STRIDE = 16
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] dep_i,
   input  logic              take_i,
   output logic [ADDR_W-1:0] nxt_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

   logic [ADDR_W-1:0] seq_w;
   assign seq_w = cur_i + STEP;
   assign nxt_o = take_i ? dep_i : seq_w;
endmodule

// File: rtl/desc_cond_eval.sv
module desc_cond_eval
   import dce_pkg::*;
#(
   parameter int unsigned STAT_W   = 4,
   parameter int unsigned SEL_W    = 32,
   parameter int unsigned MASK_LSB = 16,
   parameter int unsigned VAL_LSB  = 0,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned STRIDE   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_i,
   input  logic [1:0]        irq_mode_i,
   input  logic [1:0]        br_mode_i,
   input  logic [1:0]        wait_mode_i,
   input  logic [STAT_W-1:0] dev_stat_i,
   input  logic [SEL_W-1:0]  irq_sel_i,
   input  logic [SEL_W-1:0]  br_sel_i,
   input  logic [SEL_W-1:0]  wait_sel_i,
   input  logic [ADDR_W-1:0] cur_ptr_i,
   input  logic [ADDR_W-1:0] dep_addr_i,
   output logic              irq_req_o,
   output logic              wait_o,
   output logic              branch_o,
   output logic [ADDR_W-1:0] next_ptr_o,
   output logic              dec_valid_o
);
   if (MASK_LSB + STAT_W > SEL_W || VAL_LSB + STAT_W > SEL_W) begin : g_bad_fields
      $error("desc_cond_eval: select fields exceed SEL_W");
   end
   if (STRIDE == 0 || STRIDE >= (64'd1 << ADDR_W)) begin : g_bad_stride
      $error("desc_cond_eval: STRIDE out of range");
   end

   logic [SEL_W-1:0] sel_a  [N_ACT];
   act_mode_e        mode_a [N_ACT];
   logic [N_ACT-1:0] match_w, fire_w;
   logic [ADDR_W-1:0] nxt_w;

   assign sel_a[ACT_IRQ]  = irq_sel_i;
   assign sel_a[ACT_BR]   = br_sel_i;
   assign sel_a[ACT_WT]   = wait_sel_i;
   assign mode_a[ACT_IRQ] = act_mode_e'(irq_mode_i);
   assign mode_a[ACT_BR]  = act_mode_e'(br_mode_i);
   assign mode_a[ACT_WT]  = act_mode_e'(wait_mode_i);

   for (genvar a = 0; a < N_ACT; a++) begin : g_act
      dce_match #(
         .STAT_W(STAT_W), .SEL_W(SEL_W), .MASK_LSB(MASK_LSB), .VAL_LSB(VAL_LSB)
      ) u_match (
         .stat_i (dev_stat_i),
         .sel_i  (sel_a[a]),
         .match_o(match_w[a])
      );
      dce_decide u_dec (
         .mode_i (mode_a[a]),
         .match_i(match_w[a]),
         .fire_o (fire_w[a])
      );
   end

   dce_nextptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_nxt (
      .cur_i (cur_ptr_i),
      .dep_i (dep_addr_i),
      .take_i(fire_w[ACT_BR]),
      .nxt_o (nxt_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req_o   <= 1'b0;
         wait_o      <= 1'b0;
         branch_o    <= 1'b0;
         next_ptr_o  <= '0;
         dec_valid_o <= 1'b0;
      end else begin
         dec_valid_o <= eval_i;
         irq_req_o   <= eval_i & fire_w[ACT_IRQ];
         if (eval_i) begin
            wait_o     <= fire_w[ACT_WT];
            branch_o   <= fire_w[ACT_BR];
            next_ptr_o <= nxt_w;
         end
      end
   end

   assert_irq_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> $past(eval_i));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_i |=> ($stable(next_ptr_o) && $stable(wait_o) && $stable(branch_o) && !dec_valid_o));
   assert_branch_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_i && fire_w[ACT_BR]) |=> (branch_o && next_ptr_o == $past(dep_addr_i)));
   assert_never_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_i && irq_mode_i == MODE_NEVER) |=> !irq_req_o);
   assert_always_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_i && wait_mode_i == MODE_ALWAYS) |=> wait_o);
endmodule

// File: tb/sim_desc_cond_eval.sv
module sim_desc_cond_eval;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eval_i = 1'b0;
   logic [1:0]  irq_mode_i = '0, br_mode_i = '0, wait_mode_i = '0;
   logic [3:0]  dev_stat_i = '0;
   logic [31:0] irq_sel_i = '0, br_sel_i = '0, wait_sel_i = '0;
   logic [31:0] cur_ptr_i = '0, dep_addr_i = '0;
   logic        irq_req_o, wait_o, branch_o, dec_valid_o;
   logic [31:0] next_ptr_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   desc_cond_eval u0 (.*);

   function automatic bit f_cond(logic [3:0] st, logic [31:0] sel);
      return ((st & sel[19:16]) == (sel[3:0] & sel[19:16]));
   endfunction

   function automatic bit f_fire(logic [1:0] m, bit c);
      case (m)
         2'b00: return 1'b0;
         2'b01: return c;
         2'b10: return !c;
         default: return 1'b1;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Apply one strobe, check all outputs, then check the hold edge.
   task automatic run_eval(string req);
      bit fi, fb, fw;
      logic [31:0] np;
      fi = f_fire(irq_mode_i, f_cond(dev_stat_i, irq_sel_i));
      fb = f_fire(br_mode_i, f_cond(dev_stat_i, br_sel_i));
      fw = f_fire(wait_mode_i, f_cond(dev_stat_i, wait_sel_i));
      np = fb ? dep_addr_i : cur_ptr_i + 32'd16;
      eval_i = 1'b1;
      @(negedge clk);
      chk({req, "/R8 irq"}, 32'(irq_req_o), 32'(fi));
      chk({req, "/R8 valid"}, 32'(dec_valid_o), 32'd1);
      chk({req, "/R6 wait"}, 32'(wait_o), 32'(fw));
      chk({req, "/R7 branch"}, 32'(branch_o), 32'(fb));
      chk({req, "/R7 ptr"}, next_ptr_o, np);
      eval_i = 1'b0;
      dev_stat_i = ~dev_stat_i;
      cur_ptr_i = cur_ptr_i ^ 32'hFFFF_0F00;
      dep_addr_i = ~dep_addr_i;
      irq_mode_i = 2'b11; br_mode_i = ~br_mode_i; wait_mode_i = ~wait_mode_i;
      @(negedge clk);
      chk("R9 irq low", 32'(irq_req_o), 32'd0);
      chk("R9 valid low", 32'(dec_valid_o), 32'd0);
      chk("R9 wait hold", 32'(wait_o), 32'(fw));
      chk("R9 branch hold", 32'(branch_o), 32'(fb));
      chk("R9 ptr hold", next_ptr_o, np);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      @(negedge clk); @(negedge clk);
      chk("R1 irq", 32'(irq_req_o), 0);
      chk("R1 wait", 32'(wait_o), 0);
      chk("R1 branch", 32'(branch_o), 0);
      chk("R1 ptr", next_ptr_o, 0);
      chk("R1 valid", 32'(dec_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: zero mask -> always true, if-true fires for every action
      dev_stat_i = 4'hA; irq_sel_i = 32'h0000_0005; br_sel_i = 32'h0000_000F;
      wait_sel_i = 32'h0; irq_mode_i = 2'b01; br_mode_i = 2'b01; wait_mode_i = 2'b01;
      cur_ptr_i = 32'h1000; dep_addr_i = 32'h2340;
      run_eval("R3 zero mask");

      // R2: bits outside 19:16 / 3:0 ignored; R4 if-false on a mismatch
      dev_stat_i = 4'h3; irq_sel_i = 32'hFFF0_FFF3 & ~32'h000F_0000 | 32'h0003_0000;
      br_sel_i = 32'hFFF3_FFF0; wait_sel_i = 32'h0003_0003;
      irq_mode_i = 2'b01; br_mode_i = 2'b10; wait_mode_i = 2'b10;
      cur_ptr_i = 32'h0000_0FF0; dep_addr_i = 32'h8000_0000;
      run_eval("R2 outside bits");

      // R6: interrupt select matches, branch select mismatches
      dev_stat_i = 4'h5; irq_sel_i = 32'h000F_0005; br_sel_i = 32'h000F_0004;
      wait_sel_i = 32'h0001_0000; irq_mode_i = 2'b01; br_mode_i = 2'b01; wait_mode_i = 2'b01;
      cur_ptr_i = 32'hFFFF_FFF0; dep_addr_i = 32'h0000_4440;
      run_eval("R6 own select, R7 wrap");

      // R5: never/always regardless of mismatching selects
      dev_stat_i = 4'h0; irq_sel_i = 32'h000F_000F; br_sel_i = 32'h000F_000F;
      wait_sel_i = 32'h000F_000F; irq_mode_i = 2'b11; br_mode_i = 2'b00; wait_mode_i = 2'b11;
      cur_ptr_i = 32'h0000_0100; dep_addr_i = 32'h0000_0900;
      run_eval("R5 never/always");
      dev_stat_i = 4'hF; irq_mode_i = 2'b00; br_mode_i = 2'b11; wait_mode_i = 2'b00;
      cur_ptr_i = 32'h0000_0100; dep_addr_i = 32'h0000_0900;
      run_eval("R5 swapped");

      // R4/R7 constrained random
      for (int i = 0; i < 300; i++) begin
         dev_stat_i = 4'($urandom);
         irq_sel_i = $urandom; br_sel_i = $urandom; wait_sel_i = $urandom;
         if ($urandom % 2) irq_sel_i[3:0] = dev_stat_i;
         if ($urandom % 2) br_sel_i[3:0] = dev_stat_i;
         if ($urandom % 2) wait_sel_i[3:0] = dev_stat_i;
         irq_mode_i = 2'($urandom); br_mode_i = 2'($urandom); wait_mode_i = 2'($urandom);
         cur_ptr_i = $urandom & 32'hFFFF_FFF0; dep_addr_i = $urandom & 32'hFFFF_FFF0;
         run_eval("R4 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule